// File: doc/BRIEF.md
# SD Request Sequencer Register Front-End

This block sits between software and the line-level machinery of an SD/SDIO host. Software writes a 32-bit argument word and a 32-bit command word into a small word-addressed register file. The top byte of the command word selects an operation. EXECUTE runs one request made of up to three phases: a command phase, a data phase and a stop phase. Each phase is present only when its flag bit is set, and the phases always run in that order. SETUP applies bus width and bus clock. SDIO-SETUP enables the reporting of card interrupts. RESET returns the block to its idle state.

Each phase is handed to an external bus engine with a one-cycle start pulse and a phase code. The engine answers with a one-cycle done pulse that carries its error flags, the response bits and the number of bytes it moved. The block files engine results into sticky status bits that software clears by writing 1 to them. It stores short or long responses into four command and four stop response words, and it accumulates the data byte count. When the operation completes, the command register reads zero, so software can poll it.

The sequencer has four states. IDLE decodes a pending command word. ISSUE raises the start pulse for the selected phase. WAIT holds until the engine's done pulse. FINISH sets the done bit and clears the command register.

The transitions are as follows:
- IDLE goes to ISSUE when EXECUTE has at least one phase, and to FINISH when it has none.
- ISSUE always goes to WAIT.
- WAIT goes to ISSUE when another phase remains and nothing forces a skip, and otherwise goes to FINISH.
- FINISH always goes to IDLE.

Top module: `sdreq_seq`

## Requirements
- R1: Register word addresses are: 0 command, 1 argument, 2 status, 3 byte count, 4 bus width (bit 0 = 4-bit), 5 bus clock, 8..11 command response words 0..3, and 12..15 stop response words 0..3. After reset, all of them read 0 and `irq` is 0. When an EXECUTE completes, the command register reads 0 and status bit 31 (done) is set.
- R2: The EXECUTE operation code is 3 in command bits [31:24]. The flags are:
  - bit 0: send a command.
  - bits 4, 5, 6: data write, data read, data stream.
  - bit 7: send a stop.
  
  The enabled phases start strictly in the order command (phase code 1), data (2), stop (3). Each start is a single-cycle `eng_start` pulse.
- R3: Response flags are bit 1 (command response expected) and bit 8 (stop response expected). A long response is selected by bit 2 (command) or bit 9 (stop), and it loads all four words of that phase from `eng_rsp`. A short response loads only word 0 from `eng_rsp[31:0]` and leaves words 1..3 unchanged.
- R4: Status bit 3 is set when an expected command response times out, and status bit 2 is set when the command is lost. Either event skips the data and stop phases and goes straight to completion.
- R5: A CRC error reported by the engine sets status bit 4 (command) or bit 6 (stop) only when the phase's CRC-check flag is set (bit 3 for command, bit 10 for stop). A CRC error does not skip later phases.
- R6: Status bits are sticky. Writing 1 to a bit of the status register clears that bit, and writing 0 leaves it unchanged.
- R7: SETUP (operation code 1) never sets done. If flag bit 0 is set, the bus width changes: bit 3 selects 4-bit and bit 2 selects 1-bit. If flag bit 1 is set, the argument register is copied into the bus clock register. A SETUP with neither bit 0 nor bit 1 set changes nothing.
- R8: SDIO-SETUP (operation code 2) sets the interrupt enable from its bit 0. Status bit 10 is set while the enable is 1 and `sdio_irq_in` is high. While the enable is 0, `sdio_irq_in` has no effect.
- R9: RESET (operation code 4) clears every of the following and leaves the command register at 0:
  - status
  - argument
  - byte count
  - response words
  - bus width
  - bus clock
  - the SDIO enable
- R10: A write to the command register while a request is in progress is ignored, and it starts no phase.
- R11: A rising edge on `card_present[0]` sets status bit 0, and a rising edge on `card_present[1]` sets status bit 1. A level that stays high sets nothing.
- R12: In the data phase, a timeout sets status bit 7 and skips the stop phase. A CRC error sets bit 9 and a programming error sets bit 8, and neither of them skips. The byte count is cleared when an EXECUTE starts, and `eng_bytes` is added to it after each data phase that does not time out.
- R13: `irq` is high exactly when any status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register word address for reads and writes |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, combinational on `reg_addr` |
| eng_start | output | 1 | One-cycle phase start pulse to the bus engine |
| eng_phase | output | 2 | Active phase: 0 none, 1 command, 2 data, 3 stop |
| eng_rsp_exp | output | 1 | The active phase expects a response |
| eng_rsp_long | output | 1 | The expected response is 136 bits |
| eng_done | input | 1 | One-cycle phase completion pulse from the engine |
| eng_cmd_lost | input | 1 | With done: the command could not be sent |
| eng_timeout | input | 1 | With done: response or data timeout |
| eng_crc_err | input | 1 | With done: CRC mismatch |
| eng_prog_err | input | 1 | With done: data programming error |
| eng_rsp | input | RSP_WORDS*DW | With done: response bits, word 0 in the low bits |
| eng_bytes | input | DW | With done: bytes moved by a data phase |
| bus_wide | output | 1 | 1 for a 4-bit bus, 0 for a 1-bit bus |
| bus_clk_hz | output | DW | Applied bus clock frequency |
| sdio_irq_in | input | 1 | Card interrupt level |
| card_present | input | 2 | Card presence for slots 0 and 1 |
| irq | output | 1 | Any status bit set |

## Verification
The assertions take the engine to be well behaved. It raises `eng_done` only in the WAIT state and for exactly one cycle, and its error flags are meaningful only alongside that pulse. The bench's engine model keeps to this. It answers each start pulse only after a latency of at least one cycle, drops `done` on the following cycle, and drives inputs on the falling edge. Software is assumed to poll the command register until it reads zero before it writes a new command. Every scenario waits for that, except the deliberate write during a busy request.

// File: rtl/sdreq_pkg.sv
`timescale 1ns/1ps
package sdreq_pkg;
    typedef enum logic [1:0] {PH_NONE = 2'd0, PH_CMD = 2'd1, PH_DATA = 2'd2, PH_STOP = 2'd3} phase_e;
    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_FIN} state_e;

    localparam logic [7:0] OP_SETUP = 8'd1;
    localparam logic [7:0] OP_SDIO  = 8'd2;
    localparam logic [7:0] OP_EXEC  = 8'd3;
    localparam logic [7:0] OP_RESET = 8'd4;

    // request flag positions (decoded by software, so fixed)
    localparam int F_CMD   = 0;
    localparam int F_CRSP  = 1;
    localparam int F_CLONG = 2;
    localparam int F_CCRC  = 3;
    localparam int F_DWR   = 4;
    localparam int F_DSTR  = 6;
    localparam int F_STOP  = 7;
    localparam int F_SRSP  = 8;
    localparam int F_SLONG = 9;
    localparam int F_SCRC  = 10;
    // setup flag positions
    localparam int G_WIDTH = 0;
    localparam int G_CLOCK = 1;
    localparam int G_NARROW = 2;
    localparam int G_WIDE  = 3;

    // status bit positions
    localparam int B_DONE  = 31;
    localparam int B_SDIO  = 10;
    localparam int B_DCRC  = 9;
    localparam int B_DPROG = 8;
    localparam int B_DTO   = 7;
    localparam int B_SCRC  = 6;
    localparam int B_STO   = 5;
    localparam int B_CCRC  = 4;
    localparam int B_CTO   = 3;
    localparam int B_CLOST = 2;

    // register word addresses
    localparam int A_CMD   = 0;
    localparam int A_ARG   = 1;
    localparam int A_STAT  = 2;
    localparam int A_BYTES = 3;
    localparam int A_WIDTH = 4;
    localparam int A_CLK   = 5;
    localparam int A_CRSP  = 8;
endpackage

// File: rtl/sdreq_phase_pick.sv
`timescale 1ns/1ps
module sdreq_phase_pick
    import sdreq_pkg::*;
(
    input  phase_e cur,
    input  logic   want_cmd,
    input  logic   want_data,
    input  logic   want_stop,
    output phase_e nxt
);
    always_comb begin
        nxt = PH_NONE;
        unique case (cur)
            PH_NONE: begin
                if (want_cmd)       nxt = PH_CMD;
                else if (want_data) nxt = PH_DATA;
                else if (want_stop) nxt = PH_STOP;
            end
            PH_CMD: begin
                if (want_data)      nxt = PH_DATA;
                else if (want_stop) nxt = PH_STOP;
            end
            PH_DATA: begin
                if (want_stop)      nxt = PH_STOP;
            end
            PH_STOP: nxt = PH_NONE;
        endcase
    end
endmodule

// File: rtl/sdreq_status.sv
`timescale 1ns/1ps
module sdreq_status #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] set_m,
    input  logic [W-1:0] w1c_m,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (clr) q <= '0;
        else          q <= (q & ~w1c_m) | set_m;
    end

    // a written-one bit without a simultaneous set must read zero afterwards
    assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (|(w1c_m & ~set_m))) |=> ((q & $past(w1c_m & ~set_m)) == '0))
        else $error("status bit survived write-one-clear");

    // hardware events are never lost to a clear in the same cycle
    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (|set_m)) |=> ((q & $past(set_m)) == $past(set_m)))
        else $error("status set lost");
endmodule

// File: rtl/sdreq_rsp_bank.sv
`timescale 1ns/1ps
module sdreq_rsp_bank #(
    parameter int WORDS = 4,
    parameter int W     = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               cap,
    input  logic               long_rsp,
    input  logic [WORDS*W-1:0] din,
    output logic [WORDS*W-1:0] q
);
    localparam int TOTAL = WORDS * W;

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic load;
        if (g == 0) begin : g_first
            assign load = cap;
        end else begin : g_rest
            assign load = cap && long_rsp;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    q[g*W +: W] <= '0;
            else if (clr)  q[g*W +: W] <= '0;
            else if (load) q[g*W +: W] <= din[g*W +: W];
        end
    end

    // a short response must leave the upper words alone
    assert_short_keeps_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && !long_rsp && !clr) |=> (q[TOTAL-1:W] == $past(q[TOTAL-1:W])))
        else $error("short response touched upper words");
endmodule

// File: rtl/sdreq_seq.sv
`timescale 1ns/1ps
module sdreq_seq
    import sdreq_pkg::*;
#(
    parameter int AW        = 4,
    parameter int DW        = 32,
    parameter int RSP_WORDS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_we,
    input  logic [AW-1:0]           reg_addr,
    input  logic [DW-1:0]           reg_wdata,
    output logic [DW-1:0]           reg_rdata,
    output logic                    eng_start,
    output logic [1:0]              eng_phase,
    output logic                    eng_rsp_exp,
    output logic                    eng_rsp_long,
    input  logic                    eng_done,
    input  logic                    eng_cmd_lost,
    input  logic                    eng_timeout,
    input  logic                    eng_crc_err,
    input  logic                    eng_prog_err,
    input  logic [RSP_WORDS*DW-1:0] eng_rsp,
    input  logic [DW-1:0]           eng_bytes,
    output logic                    bus_wide,
    output logic [DW-1:0]           bus_clk_hz,
    input  logic                    sdio_irq_in,
    input  logic [1:0]              card_present,
    output logic                    irq
);
    localparam int RSP_W  = RSP_WORDS * DW;
    localparam int A_SRSP = A_CRSP + RSP_WORDS;

    state_e            st_q, st_n;
    phase_e            ph_q, ph_cur, ph_nx;
    logic [DW-1:0]     cmd_q, arg_q, bytes_q, clk_q, stat_q, set_m, w1c_m;
    logic [RSP_W-1:0]  crsp_q, srsp_q;
    logic              wide_q, sdio_en_q, skip, cap_c, cap_s, do_reset, wr_cmd, pending;
    logic [1:0]        card_q;
    logic [7:0]        op;
    logic [10:0]       fl;
    logic              in_wait_done;
    int                ridx;

    assign op           = cmd_q[31:24];
    assign fl           = cmd_q[10:0];
    assign pending      = (st_q == S_IDLE) && (cmd_q != '0);
    assign do_reset     = pending && (op == OP_RESET);
    assign wr_cmd       = reg_we && (reg_addr == AW'(A_CMD)) && (st_q == S_IDLE) && (cmd_q == '0);
    assign w1c_m        = (reg_we && reg_addr == AW'(A_STAT)) ? reg_wdata : '0;
    assign ph_cur       = (st_q == S_IDLE) ? PH_NONE : ph_q;
    assign in_wait_done = (st_q == S_WAIT) && eng_done;

    sdreq_phase_pick u_pick (
        .cur       (ph_cur),
        .want_cmd  (fl[F_CMD]),
        .want_data (|fl[F_DSTR:F_DWR]),
        .want_stop (fl[F_STOP]),
        .nxt       (ph_nx)
    );

    // engine result -> status events, skip decision, response capture
    always_comb begin
        set_m = '0;
        skip  = 1'b0;
        cap_c = 1'b0;
        cap_s = 1'b0;
        set_m[1:0]    = card_present & ~card_q;
        set_m[B_SDIO] = sdio_en_q & sdio_irq_in;
        if (st_q == S_FIN) set_m[B_DONE] = 1'b1;
        if (in_wait_done) begin
            case (ph_q)
                PH_CMD: begin
                    if (eng_cmd_lost) begin
                        set_m[B_CLOST] = 1'b1;
                        skip           = 1'b1;
                    end else if (fl[F_CRSP]) begin
                        if (eng_timeout) begin
                            set_m[B_CTO] = 1'b1;
                            skip         = 1'b1;
                        end else begin
                            cap_c         = 1'b1;
                            set_m[B_CCRC] = fl[F_CCRC] & eng_crc_err;
                        end
                    end
                end
                PH_DATA: begin
                    if (eng_timeout) begin
                        set_m[B_DTO] = 1'b1;
                        skip         = 1'b1;
                    end else begin
                        set_m[B_DCRC]  = eng_crc_err;
                        set_m[B_DPROG] = eng_prog_err;
                    end
                end
                PH_STOP: begin
                    if (fl[F_SRSP]) begin
                        if (eng_timeout) begin
                            set_m[B_STO] = 1'b1;
                            skip         = 1'b1;
                        end else begin
                            cap_s         = 1'b1;
                            set_m[B_SCRC] = fl[F_SCRC] & eng_crc_err;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // next state
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            S_IDLE:  if (pending && op == OP_EXEC) st_n = (ph_nx != PH_NONE) ? S_ISSUE : S_FIN;
            S_ISSUE: st_n = S_WAIT;
            S_WAIT:  if (eng_done) st_n = (skip || ph_nx == PH_NONE) ? S_FIN : S_ISSUE;
            S_FIN:   st_n = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= S_IDLE;
            ph_q <= PH_NONE;
        end else begin
            st_q <= st_n;
            if (st_n == S_ISSUE && st_q != S_ISSUE) ph_q <= ph_nx;
        end
    end

    // register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0; arg_q <= '0; bytes_q <= '0; clk_q <= '0;
            wide_q <= 1'b0; sdio_en_q <= 1'b0; card_q <= '0;
        end else begin
            card_q <= card_present;
            if (wr_cmd) cmd_q <= reg_wdata;
            if (reg_we && reg_addr == AW'(A_ARG)) arg_q <= reg_wdata;
            if (pending) begin
                if (op != OP_EXEC) cmd_q <= '0;
                unique case (op)
                    OP_SETUP: begin
                        if (cmd_q[G_WIDTH]) begin
                            if (cmd_q[G_WIDE])        wide_q <= 1'b1;
                            else if (cmd_q[G_NARROW]) wide_q <= 1'b0;
                        end
                        if (cmd_q[G_CLOCK]) clk_q <= arg_q;
                    end
                    OP_SDIO:  sdio_en_q <= cmd_q[0];
                    OP_EXEC:  bytes_q <= '0;
                    OP_RESET: begin
                        arg_q <= '0; bytes_q <= '0; clk_q <= '0;
                        wide_q <= 1'b0; sdio_en_q <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (in_wait_done && ph_q == PH_DATA && !eng_timeout) bytes_q <= bytes_q + eng_bytes;
            if (st_q == S_FIN) cmd_q <= '0;
        end
    end

    sdreq_status #(.W(DW)) u_stat (
        .clk(clk), .rst_n(rst_n), .clr(do_reset), .set_m(set_m), .w1c_m(w1c_m), .q(stat_q)
    );
    sdreq_rsp_bank #(.WORDS(RSP_WORDS), .W(DW)) u_crsp (
        .clk(clk), .rst_n(rst_n), .clr(do_reset), .cap(cap_c), .long_rsp(fl[F_CLONG]),
        .din(eng_rsp), .q(crsp_q)
    );
    sdreq_rsp_bank #(.WORDS(RSP_WORDS), .W(DW)) u_srsp (
        .clk(clk), .rst_n(rst_n), .clr(do_reset), .cap(cap_s), .long_rsp(fl[F_SLONG]),
        .din(eng_rsp), .q(srsp_q)
    );

    // outputs
    always_comb begin
        eng_start    = (st_q == S_ISSUE);
        eng_phase    = PH_NONE;
        eng_rsp_exp  = 1'b0;
        eng_rsp_long = 1'b0;
        if (st_q == S_ISSUE || st_q == S_WAIT) begin
            eng_phase = ph_q;
            if (ph_q == PH_CMD) begin
                eng_rsp_exp  = fl[F_CRSP];
                eng_rsp_long = fl[F_CLONG];
            end else if (ph_q == PH_STOP) begin
                eng_rsp_exp  = fl[F_SRSP];
                eng_rsp_long = fl[F_SLONG];
            end
        end
        bus_wide   = wide_q;
        bus_clk_hz = clk_q;
        irq        = |stat_q;
    end

    // read mux
    always_comb begin
        ridx      = int'(reg_addr);
        reg_rdata = '0;
        if (ridx == A_CMD)        reg_rdata = cmd_q;
        else if (ridx == A_ARG)   reg_rdata = arg_q;
        else if (ridx == A_STAT)  reg_rdata = stat_q;
        else if (ridx == A_BYTES) reg_rdata = bytes_q;
        else if (ridx == A_WIDTH) reg_rdata = {{(DW-1){1'b0}}, wide_q};
        else if (ridx == A_CLK)   reg_rdata = clk_q;
        else if (ridx >= A_CRSP && ridx < A_SRSP) reg_rdata = crsp_q[(ridx-A_CRSP)*DW +: DW];
        else if (ridx >= A_SRSP && ridx < A_SRSP + RSP_WORDS) reg_rdata = srsp_q[(ridx-A_SRSP)*DW +: DW];
    end

    // ---- assertions ----
    logic [1:0] chk_last_ph;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                chk_last_ph <= 2'd0;
        else if (st_q == S_IDLE)   chk_last_ph <= 2'd0;
        else if (eng_start)        chk_last_ph <= eng_phase;
    end

    assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start) else $error("start longer than one cycle");

    assert_phase_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> (eng_phase > chk_last_ph)) else $error("phase out of order");

    assert_done_clears_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[B_DONE]) |-> (cmd_q == '0)) else $error("done with command pending");

    assert_timeout_skips_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait_done && ph_q == PH_CMD && (eng_cmd_lost || (fl[F_CRSP] && eng_timeout)))
        |=> (st_q == S_FIN)) else $error("command failure did not skip");

    assert_busy_ignores_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_ISSUE || st_q == S_WAIT) |=> $stable(cmd_q)) else $error("command changed while busy");

    assert_reset_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
        do_reset |=> (stat_q == '0 && cmd_q == '0 && arg_q == '0)) else $error("reset op incomplete");
endmodule

// File: tb/tb_sdreq_seq.sv
`timescale 1ns/1ps
module tb_sdreq_seq;
    localparam int AD_CMD = 0, AD_ARG = 1, AD_STAT = 2, AD_BYTES = 3;
    localparam int AD_WIDTH = 4, AD_CLK = 5, AD_CRSP = 8, AD_SRSP = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic eng_start, eng_rsp_exp, eng_rsp_long, bus_wide, irq;
    logic [1:0] eng_phase;
    logic eng_done = 1'b0, eng_cmd_lost = 1'b0, eng_timeout = 1'b0, eng_crc_err = 1'b0, eng_prog_err = 1'b0;
    logic [127:0] eng_rsp = '0;
    logic [31:0] eng_bytes = '0;
    logic [31:0] bus_clk_hz;
    logic sdio_irq_in = 1'b0;
    logic [1:0] card_present = 2'b00;

    int n_chk = 0, n_err = 0;
    int lat = 2;
    int exp_ph[$];
    logic r_to[4], r_crc[4], r_prog[4], r_lost[4];
    logic [127:0] r_rsp[4];
    logic [31:0] r_bytes;

    always #4 clk = ~clk;

    sdreq_seq dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .eng_start(eng_start), .eng_phase(eng_phase),
        .eng_rsp_exp(eng_rsp_exp), .eng_rsp_long(eng_rsp_long), .eng_done(eng_done),
        .eng_cmd_lost(eng_cmd_lost), .eng_timeout(eng_timeout), .eng_crc_err(eng_crc_err),
        .eng_prog_err(eng_prog_err), .eng_rsp(eng_rsp), .eng_bytes(eng_bytes),
        .bus_wide(bus_wide), .bus_clk_hz(bus_clk_hz), .sdio_irq_in(sdio_irq_in),
        .card_present(card_present), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural engine: checks every start against the expected phase queue
    initial begin
        forever begin
            @(negedge clk);
            eng_done = 1'b0;
            if (eng_start) begin
                int ph;
                ph = int'(eng_phase);
                if (exp_ph.size() == 0) chk("R10 unexpected phase start", 32'(ph), 32'hFFFF_FFFF);
                else chk("R2 phase order", 32'(ph), 32'(exp_ph.pop_front()));
                repeat (lat) @(negedge clk);
                eng_done     = 1'b1;
                eng_cmd_lost = r_lost[ph];
                eng_timeout  = r_to[ph];
                eng_crc_err  = r_crc[ph];
                eng_prog_err = r_prog[ph];
                eng_rsp      = r_rsp[ph];
                eng_bytes    = r_bytes;
            end
        end
    end

    // reference: phases expected for a request given the scripted engine results
    function automatic void push_phases(input logic [31:0] c);
        if (c[0]) begin
            exp_ph.push_back(1);
            if (r_lost[1] || (c[1] && r_to[1])) return;
        end
        if (|c[6:4]) begin
            exp_ph.push_back(2);
            if (r_to[2]) return;
        end
        if (c[7]) exp_ph.push_back(3);
    endfunction

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a[3:0]; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a[3:0];
        #1 d = reg_rdata;
    endtask

    task automatic poll();
        logic [31:0] v;
        for (int i = 0; i < 300; i++) begin
            rd(AD_CMD, v);
            if (v == 32'h0) break;
        end
    endtask

    task automatic expect_reg(input string tag, input int a, input logic [31:0] e);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, e);
    endtask

    task automatic exec(input string tag, input logic [31:0] c);
        push_phases(c);
        wr(AD_CMD, c);
        poll();
        chk({tag, " phases left"}, 32'(exp_ph.size()), 32'd0);
    endtask

    task automatic clear_all();
        wr(AD_STAT, 32'hFFFF_FFFF);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            r_to[i] = 0; r_crc[i] = 0; r_prog[i] = 0; r_lost[i] = 0; r_rsp[i] = '0;
        end
        r_rsp[1] = {32'hC4C4_C4C4, 32'hC3C3_C3C3, 32'hC2C2_C2C2, 32'hC1C1_C1C1};
        r_rsp[3] = {32'hE4E4_E4E4, 32'hE3E3_E3E3, 32'hE2E2_E2E2, 32'hE1E1_E1E1};
        r_bytes  = 32'd512;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_reg("R1 reset cmd", AD_CMD, 32'h0);
        expect_reg("R1 reset status", AD_STAT, 32'h0);
        chk("R1 reset irq", {31'b0, irq}, 32'h0);
        chk("R1 reset start", {31'b0, eng_start}, 32'h0);

        // R1/R3 command with short response
        exec("R1", 32'h0300_0003);
        expect_reg("R1 done status", AD_STAT, 32'h8000_0000);
        expect_reg("R3 short word0", AD_CRSP, 32'hC1C1_C1C1);
        expect_reg("R3 short word1 untouched", AD_CRSP + 1, 32'h0);
        chk("R13 irq with done", {31'b0, irq}, 32'h1);

        // R6 write-one-clear, R13 irq drops
        wr(AD_STAT, 32'h0000_0001);
        expect_reg("R6 write of other bit keeps done", AD_STAT, 32'h8000_0000);
        wr(AD_STAT, 32'h8000_0000);
        expect_reg("R6 cleared", AD_STAT, 32'h0);
        chk("R13 irq low", {31'b0, irq}, 32'h0);

        // R3 long response
        exec("R3", 32'h0300_0007);
        expect_reg("R3 long word3", AD_CRSP + 3, 32'hC4C4_C4C4);
        expect_reg("R3 long word1", AD_CRSP + 1, 32'hC2C2_C2C2);
        clear_all();

        // R2 full request, R12 byte count
        exec("R2", 32'h0300_01A3);
        expect_reg("R12 bytes", AD_BYTES, 32'd512);
        expect_reg("R3 stop word0", AD_SRSP, 32'hE1E1_E1E1);
        expect_reg("R3 stop word1 untouched", AD_SRSP + 1, 32'h0);
        expect_reg("R2 status", AD_STAT, 32'h8000_0000);
        clear_all();

        // R4 command response timeout skips data and stop, bytes cleared
        r_to[1] = 1;
        exec("R4", 32'h0300_01A3);
        expect_reg("R4 status", AD_STAT, 32'h8000_0008);
        expect_reg("R12 bytes cleared", AD_BYTES, 32'h0);
        r_to[1] = 0;
        clear_all();
        r_lost[1] = 1;
        exec("R4 lost", 32'h0300_0081);
        expect_reg("R4 lost status", AD_STAT, 32'h8000_0004);
        r_lost[1] = 0;
        clear_all();

        // R5 CRC only with check flag, no skip
        r_crc[1] = 1;
        exec("R5 nocheck", 32'h0300_0003);
        expect_reg("R5 no crc bit", AD_STAT, 32'h8000_0000);
        clear_all();
        exec("R5 check", 32'h0300_008B);
        expect_reg("R5 crc bit", AD_STAT, 32'h8000_0010);
        r_crc[1] = 0;
        clear_all();

        // R12 data timeout skips stop; crc/prog do not
        r_to[2] = 1;
        exec("R12 timeout", 32'h0300_01A0);
        expect_reg("R12 timeout status", AD_STAT, 32'h8000_0080);
        expect_reg("R12 no bytes on timeout", AD_BYTES, 32'h0);
        r_to[2] = 0; r_crc[2] = 1; r_prog[2] = 1;
        clear_all();
        exec("R12 errors", 32'h0300_01A0);
        expect_reg("R12 error status", AD_STAT, 32'h8000_0300);
        r_crc[2] = 0; r_prog[2] = 0;
        clear_all();

        // R10 command write while busy is ignored
        lat = 15;
        push_phases(32'h0300_0003);
        wr(AD_CMD, 32'h0300_0003);
        repeat (4) @(negedge clk);
        wr(AD_CMD, 32'h0300_0080);
        poll();
        repeat (10) @(negedge clk);
        chk("R10 phases left", 32'(exp_ph.size()), 32'd0);
        expect_reg("R10 cmd zero", AD_CMD, 32'h0);
        lat = 2;
        clear_all();

        // R7 setup
        wr(AD_ARG, 32'd25_000_000);
        wr(AD_CMD, 32'h0100_000B);
        poll();
        expect_reg("R7 wide", AD_WIDTH, 32'h1);
        expect_reg("R7 clock", AD_CLK, 32'd25_000_000);
        expect_reg("R7 no done", AD_STAT, 32'h0);
        wr(AD_ARG, 32'd400_000);
        wr(AD_CMD, 32'h0100_0004);
        poll();
        expect_reg("R7 width unchanged", AD_WIDTH, 32'h1);
        expect_reg("R7 clock unchanged", AD_CLK, 32'd25_000_000);
        wr(AD_CMD, 32'h0100_0005);
        poll();
        expect_reg("R7 narrow", AD_WIDTH, 32'h0);

        // R8 sdio interrupt enable
        sdio_irq_in = 1'b1;
        repeat (4) @(negedge clk);
        expect_reg("R8 disabled", AD_STAT, 32'h0);
        wr(AD_CMD, 32'h0200_0001);
        poll();
        expect_reg("R8 enabled", AD_STAT, 32'h0000_0400);
        sdio_irq_in = 1'b0;
        clear_all();
        expect_reg("R8 cleared", AD_STAT, 32'h0);

        // R11 card insertion edges
        card_present = 2'b01;
        repeat (3) @(negedge clk);
        expect_reg("R11 card0", AD_STAT, 32'h0000_0001);
        clear_all();
        repeat (3) @(negedge clk);
        expect_reg("R11 level ignored", AD_STAT, 32'h0);
        card_present = 2'b11;
        repeat (3) @(negedge clk);
        expect_reg("R11 card1", AD_STAT, 32'h0000_0002);

        // R9 reset operation
        wr(AD_CMD, 32'h0100_000B);
        poll();
        exec("R9 prep", 32'h0300_0023);
        wr(AD_CMD, 32'h0400_0000);
        poll();
        expect_reg("R9 status", AD_STAT, 32'h0);
        expect_reg("R9 arg", AD_ARG, 32'h0);
        expect_reg("R9 bytes", AD_BYTES, 32'h0);
        expect_reg("R9 rsp", AD_CRSP, 32'h0);
        expect_reg("R9 width", AD_WIDTH, 32'h0);
        expect_reg("R9 clock", AD_CLK, 32'h0);
        sdio_irq_in = 1'b1;
        repeat (3) @(negedge clk);
        expect_reg("R9 sdio enable cleared", AD_STAT, 32'h0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule